// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block is a clocked model of a 16-bit transceiver that sits between two buses, A and B. The width is split into two 8-bit sections, and each section has its own controls. The two sections can therefore work as two separate byte-wide transceivers, or be driven together as one 16-bit transceiver. Inside every section there are two storage registers, one for each direction. The A-to-B register is loaded from the A port and feeds the B port. The B-to-A register is loaded from the B port and feeds the A port.

Each direction of each section has three active-low controls. The first is a direction enable, which gates both loading and driving. The second is a capture control: while it is low together with the direction enable, the register follows its input on every clock edge. Once it goes high, the register keeps the last value it took. The third is an output control.

Pins that could be tri-stated are replaced by separate signals. Each port has a data input, a data output and an active-high drive flag per section. The drive flag is purely combinational from the controls. The output data always shows the register contents, so the drive flag alone decides whether a bus would actually see that value.

Top module: `bus_xcvr`

## Requirements
- R1: Controls of section s (bits 8s+7..8s) affect only that section's output bits and drive flag; the other section is unchanged.
- R2: At a clock edge where a path's direction enable and capture control are both low, its register loads the input port slice, and the opposite port's output data shows that value from that edge on.
- R3: At a clock edge where the capture control is high, the register keeps its value, so the output data stays fixed while the input port changes.
- R4: After the capture control rises, the held value is the input present at the last edge where both the direction enable and the capture control were low.
- R5: A path's drive flag is 1 exactly when its direction enable and output control are both low, in the same cycle, independent of clock and reset.
- R6: With the direction enable high, the register does not load even if the capture control is low.
- R7: The A-to-B and B-to-A registers of a section are separate: both may load in the same edge, and each holds what it took.
- R8: Asserting rst_n low clears all four registers to zero at once, without waiting for a clock, and leaves the drive flags following the controls.
- R9: Turning the output control high and then low again does not disturb the stored value; the drive flag returns with the same data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release assumed synchronous |
| a_in | input | 16 | Data arriving on port A |
| a_out | output | 16 | Data presented to port A (B-to-A registers) |
| a_drv | output | 2 | Per-section drive flag for port A |
| b_in | input | 16 | Data arriving on port B |
| b_out | output | 16 | Data presented to port B (A-to-B registers) |
| b_drv | output | 2 | Per-section drive flag for port B |
| a2b_en_n | input | 2 | Per-section A-to-B direction enable, active low |
| a2b_cap_n | input | 2 | Per-section A-to-B capture control, active low |
| a2b_oe_n | input | 2 | Per-section A-to-B output control, active low |
| b2a_en_n | input | 2 | Per-section B-to-A direction enable, active low |
| b2a_cap_n | input | 2 | Per-section B-to-A capture control, active low |
| b2a_oe_n | input | 2 | Per-section B-to-A output control, active low |

## Verification
Two pairs of events can land in the same cycle. Both directions of a section can load at the same edge. A load can also happen in the same cycle in which the output control switches, so the drive flag changes while the data moves. The bench forces both pairs directly and again through a long run of random control and data words. Every edge is judged against a bench model of the two registers per section, and the drive flags are checked both before and after each edge, so a flag that lags the controls or a load that leaks into the other direction shows up as a mismatch.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
  parameter int unsigned SECT_W_DEF   = 8;
  parameter int unsigned NUM_SECT_DEF = 2;

  // Active-low control set of one direction path.
  typedef struct packed {
    logic en_n;   // direction enable: gates load and drive
    logic cap_n;  // capture control: low = follow input
    logic oe_n;   // output control
  } path_ctl_t;
endpackage

// File: rtl/xcvr_path.sv
`timescale 1ns/1ps
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int unsigned W = SECT_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  path_ctl_t    ctl,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         drive
);
  logic [W-1:0] store_q;
  logic [W-1:0] store_nxt;
  logic         load;

  // Next-state: clock enable and data.
  always_comb begin
    load      = ~ctl.en_n & ~ctl.cap_n;
    store_nxt = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     store_q <= '0;
    else if (load)  store_q <= store_nxt;
  end

  assign dout  = store_q;
  assign drive = ~(ctl.en_n | ctl.oe_n);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.en_n && !ctl.cap_n) |=> dout == $past(din));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.cap_n |=> $stable(dout));

  assert_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.en_n |=> $stable(dout));

  assert_no_drive_en_R5: assert property (@(posedge clk)
    ctl.en_n |-> !drive);

  assert_no_drive_oe_R5: assert property (@(posedge clk)
    ctl.oe_n |-> !drive);

  assert_reset_clear_R8: assert property (@(posedge clk)
    !rst_n |-> dout == '0);
endmodule

// File: rtl/xcvr_section.sv
`timescale 1ns/1ps
module xcvr_section
  import xcvr_pkg::*;
#(
  parameter int unsigned W = SECT_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  path_ctl_t    a2b_ctl,
  input  path_ctl_t    b2a_ctl,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out,
  output logic         a_drv,
  output logic         b_drv
);
  // A-to-B: loads from port A, presents on port B.
  xcvr_path #(.W(W)) u_a2b (
    .clk(clk), .rst_n(rst_n), .ctl(a2b_ctl),
    .din(a_in), .dout(b_out), .drive(b_drv)
  );

  // B-to-A: loads from port B, presents on port A.
  xcvr_path #(.W(W)) u_b2a (
    .clk(clk), .rst_n(rst_n), .ctl(b2a_ctl),
    .din(b_in), .dout(a_out), .drive(a_drv)
  );

  // R7: a load in one direction leaves the other register alone.
  assert_dir_isolated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!a2b_ctl.en_n && !a2b_ctl.cap_n && b2a_ctl.cap_n) |=> $stable(a_out));
endmodule

// File: rtl/bus_xcvr.sv
`timescale 1ns/1ps
module bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned SECT_W   = SECT_W_DEF,
  parameter int unsigned NUM_SECT = NUM_SECT_DEF,
  localparam int unsigned BUS_W   = SECT_W * NUM_SECT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BUS_W-1:0]    a_in,
  output logic [BUS_W-1:0]    a_out,
  output logic [NUM_SECT-1:0] a_drv,
  input  logic [BUS_W-1:0]    b_in,
  output logic [BUS_W-1:0]    b_out,
  output logic [NUM_SECT-1:0] b_drv,
  input  logic [NUM_SECT-1:0] a2b_en_n,
  input  logic [NUM_SECT-1:0] a2b_cap_n,
  input  logic [NUM_SECT-1:0] a2b_oe_n,
  input  logic [NUM_SECT-1:0] b2a_en_n,
  input  logic [NUM_SECT-1:0] b2a_cap_n,
  input  logic [NUM_SECT-1:0] b2a_oe_n
);
  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    path_ctl_t a2b_ctl;
    path_ctl_t b2a_ctl;

    assign a2b_ctl = '{en_n: a2b_en_n[s], cap_n: a2b_cap_n[s], oe_n: a2b_oe_n[s]};
    assign b2a_ctl = '{en_n: b2a_en_n[s], cap_n: b2a_cap_n[s], oe_n: b2a_oe_n[s]};

    xcvr_section #(.W(SECT_W)) u_sect (
      .clk    (clk),
      .rst_n  (rst_n),
      .a2b_ctl(a2b_ctl),
      .b2a_ctl(b2a_ctl),
      .a_in   (a_in [s*SECT_W +: SECT_W]),
      .b_in   (b_in [s*SECT_W +: SECT_W]),
      .a_out  (a_out[s*SECT_W +: SECT_W]),
      .b_out  (b_out[s*SECT_W +: SECT_W]),
      .a_drv  (a_drv[s]),
      .b_drv  (b_drv[s])
    );

    // R1: an idle section keeps its B-side slice whatever the other does.
    assert_sect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (a2b_en_n[s] || a2b_cap_n[s]) |=> $stable(b_out[s*SECT_W +: SECT_W]));
  end
endmodule

// File: tb/test_bus_xcvr.sv
`timescale 1ns/1ps
module test_bus_xcvr;
  localparam int NS = 2;
  localparam int SW = 8;
  localparam int BW = NS * SW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [BW-1:0] a_in, b_in, a_out, b_out;
  logic [NS-1:0] a_drv, b_drv;
  logic [NS-1:0] a2b_en_n, a2b_cap_n, a2b_oe_n;
  logic [NS-1:0] b2a_en_n, b2a_cap_n, b2a_oe_n;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [SW-1:0] ref_ab [NS];
  logic [SW-1:0] ref_ba [NS];

  always #4 clk = ~clk;

  bus_xcvr i_bus_xcvr (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
    .a2b_en_n(a2b_en_n), .a2b_cap_n(a2b_cap_n), .a2b_oe_n(a2b_oe_n),
    .b2a_en_n(b2a_en_n), .b2a_cap_n(b2a_cap_n), .b2a_oe_n(b2a_oe_n)
  );

  task automatic cmp(string req, string what, logic [BW-1:0] act, logic [BW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Compare all outputs against the bench model.
  task automatic check(string req);
    logic [BW-1:0] eb, ea;
    logic [NS-1:0] edb, eda;
    for (int s = 0; s < NS; s++) begin
      eb[s*SW +: SW] = ref_ab[s];
      ea[s*SW +: SW] = ref_ba[s];
      edb[s] = !a2b_en_n[s] && !a2b_oe_n[s];
      eda[s] = !b2a_en_n[s] && !b2a_oe_n[s];
    end
    cmp(req, "b_out", b_out, eb);
    cmp(req, "a_out", a_out, ea);
    cmp(req, "b_drv", BW'(b_drv), BW'(edb));
    cmp(req, "a_drv", BW'(a_drv), BW'(eda));
  endtask

  // One clock edge: update the model from the held inputs, then check.
  task automatic tick(string req);
    @(posedge clk);
    #1;
    if (rst_n) begin
      for (int s = 0; s < NS; s++) begin
        if (!a2b_en_n[s] && !a2b_cap_n[s]) ref_ab[s] = a_in[s*SW +: SW];
        if (!b2a_en_n[s] && !b2a_cap_n[s]) ref_ba[s] = b_in[s*SW +: SW];
      end
    end
    check(req);
  endtask

  task automatic idle_all();
    a2b_en_n = '1; a2b_cap_n = '1; a2b_oe_n = '1;
    b2a_en_n = '1; b2a_cap_n = '1; b2a_oe_n = '1;
  endtask

  task automatic t_reset_state();
    check("R8 reset");
    cmp("R8 reset", "b_out zero", b_out, '0);
    cmp("R8 reset", "a_out zero", a_out, '0);
  endtask

  task automatic t_transparent();
    a2b_en_n[0] = 0; a2b_cap_n[0] = 0; a2b_oe_n[0] = 0;
    foreach (ref_ab[i]) ;
    a_in = 16'h00A5; tick("R2");
    cmp("R2", "b_out low byte", {8'h00, b_out[7:0]}, 16'h00A5);
    a_in = 16'h003C; tick("R2");
    a_in = 16'h00FF; tick("R2");
  endtask

  task automatic t_capture_release();
    a2b_en_n[0] = 0; a2b_cap_n[0] = 0;
    a_in = 16'h0011; tick("R4");
    a_in = 16'h0022; tick("R4");
    a2b_cap_n[0] = 1;
    a_in = 16'h0033; tick("R4");
    cmp("R4", "held byte", {8'h00, b_out[7:0]}, 16'h0022);
    a_in = 16'h0044; tick("R3");
    a_in = 16'h0055; tick("R3");
    cmp("R3", "held byte", {8'h00, b_out[7:0]}, 16'h0022);
  endtask

  task automatic t_enable_blocks();
    a2b_en_n[0] = 1; a2b_cap_n[0] = 0;
    a_in = 16'h0077; tick("R6");
    cmp("R6", "no load", {8'h00, b_out[7:0]}, 16'h0022);
    a2b_cap_n[0] = 1;
  endtask

  task automatic t_drive_flags();
    for (int c = 0; c < 4; c++) begin
      a2b_en_n[1] = c[0]; a2b_oe_n[1] = c[1];
      b2a_en_n[0] = c[1]; b2a_oe_n[0] = c[0];
      #1 check("R5 comb");
      tick("R5");
    end
    a2b_en_n[1] = 1; a2b_oe_n[1] = 1; b2a_en_n[0] = 1; b2a_oe_n[0] = 1;
  endtask

  task automatic t_sections();
    a2b_en_n[1] = 0; a2b_cap_n[1] = 0; a2b_oe_n[1] = 0;
    a_in = 16'hC3_99; tick("R1");
    cmp("R1", "low byte untouched", {8'h00, b_out[7:0]}, 16'h0022);
    cmp("R1", "high byte loaded", {b_out[15:8], 8'h00}, 16'hC300);
    a2b_cap_n[1] = 1;
    tick("R1");
  endtask

  task automatic t_both_dirs();
    a2b_en_n[0] = 0; a2b_cap_n[0] = 0; a2b_oe_n[0] = 0;
    b2a_en_n[0] = 0; b2a_cap_n[0] = 0; b2a_oe_n[0] = 1;
    a_in = 16'h0012; b_in = 16'h0034; tick("R7");
    cmp("R7", "a2b byte", {8'h00, b_out[7:0]}, 16'h0012);
    cmp("R7", "b2a byte", {8'h00, a_out[7:0]}, 16'h0034);
    b2a_cap_n[0] = 1; b2a_oe_n[0] = 0;
    a_in = 16'h0056; b_in = 16'h0078; tick("R7");
    cmp("R7", "b2a kept", {8'h00, a_out[7:0]}, 16'h0034);
    a2b_cap_n[0] = 1;
  endtask

  task automatic t_reenable();
    a2b_en_n[0] = 0; a2b_cap_n[0] = 0; a2b_oe_n[0] = 0;
    a_in = 16'h005A; tick("R9");
    a2b_cap_n[0] = 1; a2b_oe_n[0] = 1;
    a_in = 16'h00E1; tick("R9");
    a2b_oe_n[0] = 0;
    #1 check("R9");
    cmp("R9", "value after re-enable", {8'h00, b_out[7:0]}, 16'h005A);
  endtask

  task automatic t_reset_async();
    a2b_oe_n = '0; a2b_en_n = '0; a2b_cap_n = '1;
    @(posedge clk); #2;
    rst_n = 0;
    #1;
    foreach (ref_ab[s]) begin ref_ab[s] = '0; ref_ba[s] = '0; end
    check("R8 async");
    cmp("R8 async", "b_drv kept", BW'(b_drv), BW'(2'b11));
    @(posedge clk); #1;
    rst_n = 1;
    tick("R8");
  endtask

  task automatic t_random();
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      a2b_en_n = r[1:0];  a2b_cap_n = r[3:2]; a2b_oe_n = r[5:4];
      b2a_en_n = r[7:6];  b2a_cap_n = r[9:8]; b2a_oe_n = r[11:10];
      a_in = 16'($urandom); b_in = 16'($urandom);
      #1 check("R5 rand");
      tick("R2 R3 R7 rand");
    end
  endtask

  initial begin
    rst_n = 0;
    a_in = '0; b_in = '0;
    idle_all();
    foreach (ref_ab[s]) begin ref_ab[s] = '0; ref_ba[s] = '0; end
    repeat (2) @(posedge clk);
    #1;
    t_reset_state();
    rst_n = 1;
    tick("R8 release");
    t_transparent();
    t_capture_release();
    t_enable_blocks();
    t_drive_flags();
    t_sections();
    t_both_dirs();
    t_reenable();
    idle_all();
    t_reset_async();
    t_random();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule